// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block gathers one horizontal line of 6-bit gray-scale codes for a column driver that sits in a chain of identical drivers. On each rising clock edge it accepts a 36-bit word that holds six dots. A one-clock start pulse arms the loader. The next 64 clock edges then deposit 64 six-dot groups into a flat array of 384 column codes. The line latch that follows reads this array.

The fill direction is selectable. It also decides which of the two start-pulse pins acts as the input and which carries the cascade pulse to the next driver in the chain. The cascade pulse is raised before the local load ends, so the next driver starts loading without a gap. After a fixed number of clocks the loader stops by itself. A rising edge on the line strobe aborts any load in progress. The dots are split into two ports of three dots each, and each port can be stored bit-inverted under its own control input.

Top module: `col_line_loader`

## Requirements
- R1: After the synchronous active-low reset, both cascade outputs are low and every column code in `line_o` reads zero.
- R2: A low-to-high change of the selected start input, sampled on a rising clock edge (edge 0), arms the loader. Edges 1 through 64 that follow each store one six-dot group, in order of arrival.
- R3: A start input held high for several clocks acts exactly like a one-clock pulse. Only its first high edge counts.
- R4: With `shift_right` high, the group stored on edge k+1 (slot k) places dot i in column 6k+i. Column c occupies bits [6c+5:6c] of `line_o`, and dot i occupies bits [6i+5:6i] of `dots_in`.
- R5: With `shift_right` low, slot k places dot i in column 6(63-k)+i. Dot order inside a group stays the same.
- R6: With `shift_right` high, `sp_right_in` is the start input and the cascade pulse appears on `sp_left_out`. With `shift_right` low, the roles are swapped. The unused output stays low, and a pulse on the unused input starts nothing.
- R7: The cascade output goes high right after the 64th rising edge that follows the start edge, and it stays high for exactly one clock.
- R8: Once 66 edges have followed the start edge, loading halts. Data offered on later edges leaves `line_o` unchanged until the next start.
- R9: A rising edge on `line_strobe` clears the slot pointer and ends the load. Groups offered on that edge and afterwards are not stored, and no cascade pulse follows.
- R10: When `inv_port_a` is high on a storing edge, dots 0 to 2 (`dots_in` bits 17:0) are stored bit-inverted. When it is low, they are stored unchanged.
- R11: When `inv_port_b` is high on a storing edge, dots 3 to 5 (`dots_in` bits 35:18) are stored bit-inverted. When it is low, they are stored unchanged.
- R12: A new start pulse that arrives while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_right | input | 1 | Fill direction and start-pin role select |
| sp_right_in | input | 1 | Start input when `shift_right` is high |
| sp_left_in | input | 1 | Start input when `shift_right` is low |
| sp_right_out | output | 1 | Cascade pulse when `shift_right` is low |
| sp_left_out | output | 1 | Cascade pulse when `shift_right` is high |
| line_strobe | input | 1 | Line strobe; its rising edge clears the slot pointer |
| inv_port_a | input | 1 | Invert dots 0 to 2 |
| inv_port_b | input | 1 | Invert dots 3 to 5 |
| dots_in | input | 36 | Six 6-bit dots, dot i at bits [6i+5:6i] |
| line_o | output | 2304 | 384 column codes, column c at bits [6c+5:6c] |

## Verification
If the slot counter is off by one, groups land one slot away from where they belong. The cascade pulse then comes a clock early or late, so the error shows on the cascade pin within the same line. A busy flag that fails to clear or to set shows up either as groups from after the halt overwriting columns, or as a line that stays empty. Both are visible in `line_o` as soon as that line finishes. Wrong inversion or a wrong direction mapping corrupts specific columns of the first line that exercises them, so the bench compares all 384 columns after every line.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
    localparam int DEF_DOT_W = 6;
    localparam int DEF_DOTS  = 6;
    localparam int DEF_SLOTS = 64;
endpackage

// File: rtl/cdl_dot_invert.sv
module cdl_dot_invert #(
    parameter int DOT_W = cdl_pkg::DEF_DOT_W,
    parameter int DOTS  = cdl_pkg::DEF_DOTS
) (
    input  logic [DOT_W*DOTS-1:0] data_i,
    input  logic                  inv_lo_i,
    input  logic                  inv_hi_i,
    output logic [DOT_W*DOTS-1:0] data_o
);
    localparam int HALF = DOTS / 2;

    // Lower half of the dots forms port A, upper half port B.
    for (genvar i = 0; i < DOTS; i++) begin : g_dot
        if (i < HALF) begin : g_lo
            assign data_o[i*DOT_W +: DOT_W] = data_i[i*DOT_W +: DOT_W] ^ {DOT_W{inv_lo_i}};
        end else begin : g_hi
            assign data_o[i*DOT_W +: DOT_W] = data_i[i*DOT_W +: DOT_W] ^ {DOT_W{inv_hi_i}};
        end
    end
endmodule

// File: rtl/cdl_sequencer.sv
module cdl_sequencer #(
    parameter int SLOTS = cdl_pkg::DEF_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      strobe_i,
    input  logic                      dir_i,
    output logic                      we_o,
    output logic [$clog2(SLOTS)-1:0]  slot_o,
    output logic                      dir_o,
    output logic                      cascade_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LAST   = SLOTS + 1;          // count at which the load halts
    localparam int CNT_W  = $clog2(LAST + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             cascade;
        logic             start_prev;
        logic             strobe_prev;
    } seq_t;

    seq_t st_d, st_q;
    logic trig_d, strobe_rise_d, we_d;

    always_comb begin
        st_d          = st_q;
        st_d.cascade  = 1'b0;
        st_d.start_prev  = start_i;
        st_d.strobe_prev = strobe_i;
        we_d          = 1'b0;
        strobe_rise_d = strobe_i & ~st_q.strobe_prev;
        trig_d        = start_i & ~st_q.start_prev & ~st_q.busy;
        if (strobe_rise_d) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (trig_d) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.dir  = dir_i;
        end else if (st_q.busy) begin
            if (st_q.cnt < CNT_W'(SLOTS)) begin
                we_d = 1'b1;
            end
            if (st_q.cnt == CNT_W'(SLOTS - 1)) begin
                st_d.cascade = 1'b1;
            end
            if (st_q.cnt == CNT_W'(LAST)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o      = we_d;
    assign slot_o    = st_q.cnt[SLOT_W-1:0];
    assign dir_o     = st_q.dir;
    assign cascade_o = st_q.cascade;

    assert_cascade_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cascade |=> !st_q.cascade);

    assert_cascade_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cascade |-> (st_q.busy && st_q.cnt == CNT_W'(SLOTS)));

    assert_arm_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.cnt == '0));

    assert_halt_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && !$past(strobe_rise_d)) |-> ($past(st_q.cnt) == CNT_W'(LAST)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LAST));

    assert_strobe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise_d |=> (!st_q.busy && !st_q.cascade));
endmodule

// File: rtl/cdl_column_store.sv
module cdl_column_store #(
    parameter int DOT_W = cdl_pkg::DEF_DOT_W,
    parameter int DOTS  = cdl_pkg::DEF_DOTS,
    parameter int SLOTS = cdl_pkg::DEF_SLOTS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [$clog2(SLOTS)-1:0]      slot_i,
    input  logic                          dir_i,
    input  logic [DOT_W*DOTS-1:0]         data_i,
    output logic [DOT_W*DOTS*SLOTS-1:0]   line_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = DOT_W * DOTS;

    logic [GRP_W-1:0]  grp_d [SLOTS];
    logic [GRP_W-1:0]  grp_q [SLOTS];
    logic [SLOT_W-1:0] idx_d;

    // Right fill: slot k -> group k. Left fill: slot k -> group SLOTS-1-k.
    always_comb begin
        idx_d = dir_i ? slot_i : (SLOT_W'(SLOTS - 1) - slot_i);
        for (int g = 0; g < SLOTS; g++) begin
            grp_d[g] = grp_q[g];
        end
        if (we_i) begin
            grp_d[idx_d] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < SLOTS; g++) begin
                grp_q[g] <= '0;
            end
        end else begin
            for (int g = 0; g < SLOTS; g++) begin
                grp_q[g] <= grp_d[g];
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign line_o[g*GRP_W +: GRP_W] = grp_q[g];
    end

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(line_o));
endmodule

// File: rtl/col_line_loader.sv
module col_line_loader #(
    parameter int DOT_W = cdl_pkg::DEF_DOT_W,
    parameter int DOTS  = cdl_pkg::DEF_DOTS,
    parameter int SLOTS = cdl_pkg::DEF_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_right,
    input  logic                        sp_right_in,
    input  logic                        sp_left_in,
    output logic                        sp_right_out,
    output logic                        sp_left_out,
    input  logic                        line_strobe,
    input  logic                        inv_port_a,
    input  logic                        inv_port_b,
    input  logic [DOT_W*DOTS-1:0]       dots_in,
    output logic [DOT_W*DOTS*SLOTS-1:0] line_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int GRP_W  = DOT_W * DOTS;

    logic              start_sel;
    logic              we;
    logic [SLOT_W-1:0] slot;
    logic              dir_run;
    logic              cascade;
    logic [GRP_W-1:0]  dots_fix;

    assign start_sel = shift_right ? sp_right_in : sp_left_in;

    cdl_dot_invert #(.DOT_W(DOT_W), .DOTS(DOTS)) u_inv (
        .data_i   (dots_in),
        .inv_lo_i (inv_port_a),
        .inv_hi_i (inv_port_b),
        .data_o   (dots_fix)
    );

    cdl_sequencer #(.SLOTS(SLOTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_sel),
        .strobe_i  (line_strobe),
        .dir_i     (shift_right),
        .we_o      (we),
        .slot_o    (slot),
        .dir_o     (dir_run),
        .cascade_o (cascade)
    );

    cdl_column_store #(.DOT_W(DOT_W), .DOTS(DOTS), .SLOTS(SLOTS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .slot_i (slot),
        .dir_i  (dir_run),
        .data_i (dots_fix),
        .line_o (line_o)
    );

    assign sp_left_out  = cascade &  dir_run;
    assign sp_right_out = cascade & ~dir_run;

    assert_one_cascade_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sp_left_out, sp_right_out}));

    assert_pin_follows_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_left_out || sp_right_out) |-> (sp_left_out == dir_run));
endmodule

// File: tb/tb_col_line_loader.sv
module tb_col_line_loader;
    localparam int DOT_W = 6;
    localparam int DOTS  = 6;
    localparam int SLOTS = 64;
    localparam int COLS  = DOTS * SLOTS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_right = 1'b1;
    logic sp_right_in = 1'b0;
    logic sp_left_in = 1'b0;
    logic sp_right_out, sp_left_out;
    logic line_strobe = 1'b0;
    logic inv_port_a = 1'b0;
    logic inv_port_b = 1'b0;
    logic [DOT_W*DOTS-1:0] dots_in = '0;
    logic [DOT_W*COLS-1:0] line_o;

    int checks = 0;
    int errors = 0;
    logic [DOT_W-1:0] exp_col [COLS];

    always #2 clk = ~clk;

    col_line_loader dut (
        .clk(clk), .rst_n(rst_n), .shift_right(shift_right),
        .sp_right_in(sp_right_in), .sp_left_in(sp_left_in),
        .sp_right_out(sp_right_out), .sp_left_out(sp_left_out),
        .line_strobe(line_strobe), .inv_port_a(inv_port_a), .inv_port_b(inv_port_b),
        .dots_in(dots_in), .line_o(line_o)
    );

    function automatic int col_of(bit dir, int slot, int dot);
        return dir ? (DOTS*slot + dot) : (DOTS*(SLOTS-1-slot) + dot);
    endfunction

    function automatic logic [DOT_W-1:0] dot_val(logic [DOT_W*DOTS-1:0] d, int dot, bit ia, bit ib);
        logic [DOT_W-1:0] v;
        v = d[dot*DOT_W +: DOT_W];
        if (dot < DOTS/2) v = v ^ {DOT_W{ia}};
        else              v = v ^ {DOT_W{ib}};
        return v;
    endfunction

    task automatic check_bit(string req, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
        end
    endtask

    task automatic compare_line(string req);
        int bad = 0;
        int first = -1;
        for (int c = 0; c < COLS; c++) begin
            if (line_o[c*DOT_W +: DOT_W] !== exp_col[c]) begin
                bad++;
                if (first < 0) first = c;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s column %0d actual=%0h expected=%0h (%0d columns differ)",
                     req, first, line_o[first*DOT_W +: DOT_W], exp_col[first], bad);
        end
    endtask

    // invmode: 0 none, 1 port A, 2 port B, 3 random per clock
    task automatic run_line(bit dir, int hold, int restart_at, int strobe_at,
                            bit wrong_pin, int invmode, string req);
        bit load = !wrong_pin;
        bit sp;
        bit ia, ib;
        logic [DOT_W*DOTS-1:0] d;
        for (int k = 0; k <= 70; k++) begin
            @(negedge clk);
            if (k >= 1) begin
                bit ec = load && (strobe_at == 0) && (k - 1 == SLOTS);
                check_bit({req, " R7 cascade"}, dir ? sp_left_out : sp_right_out, ec);
                check_bit({req, " R6 idle pin"}, dir ? sp_right_out : sp_left_out, 1'b0);
            end
            shift_right = dir;
            sp = (k < hold) || (k == restart_at);
            sp_right_in = (dir ^ wrong_pin) ? sp : 1'b0;
            sp_left_in  = (dir ^ wrong_pin) ? 1'b0 : sp;
            line_strobe = (strobe_at > 0) && (k >= strobe_at) && (k < strobe_at + 2);
            d = {$urandom, $urandom};
            case (invmode)
                1: begin ia = 1; ib = 0; end
                2: begin ia = 0; ib = 1; end
                3: begin ia = 1'($urandom); ib = 1'($urandom); end
                default: begin ia = 0; ib = 0; end
            endcase
            dots_in = d; inv_port_a = ia; inv_port_b = ib;
            if (load && k >= 1 && k <= SLOTS && (strobe_at == 0 || k < strobe_at)) begin
                for (int i = 0; i < DOTS; i++) exp_col[col_of(dir, k-1, i)] = dot_val(d, i, ia, ib);
            end
        end
        @(negedge clk);
        sp_right_in = 0; sp_left_in = 0; line_strobe = 0;
        @(negedge clk);
        compare_line(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int c = 0; c < COLS; c++) exp_col[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 reset left out", sp_left_out, 1'b0);
        check_bit("R1 reset right out", sp_right_out, 1'b0);
        compare_line("R1 reset line zero");

        run_line(1, 1, 0, 0, 0, 0, "R2 R4 right fill");
        run_line(0, 1, 0, 0, 0, 0, "R5 left fill");
        run_line(1, 4, 0, 0, 0, 1, "R3 held start R10 inv A");
        run_line(0, 1, 20, 0, 0, 2, "R12 restart ignored R11 inv B");
        run_line(1, 1, 0, 0, 1, 3, "R6 wrong pin right");
        run_line(0, 1, 0, 0, 1, 3, "R6 wrong pin left");
        run_line(1, 1, 0, 25, 0, 3, "R9 strobe abort right");
        run_line(0, 1, 0, 40, 0, 3, "R9 strobe abort left");
        // R8: data after the halt was offered in every line above; random lines follow
        for (int n = 0; n < 4; n++) begin
            run_line(1'($urandom), 1 + int'($urandom % 3), 0, 0, 0, 3, "R8 random line");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule